// File: doc/BRIEF.md
# Time-Dithered DAC Code Generator

This block lifts an 8-bit DAC to 10-bit effective resolution by time dithering. A 10-bit target value is split into an 8-bit base code (its upper bits) and a 2-bit fraction (its lower bits). The block drives the DAC with either the base code or the next code up. A four-step modulo counter decides which one: during the first `fraction` steps of each four-step dither period it selects the higher code, and for the rest it selects the base code. After an external low-pass filter, the average DAC level equals the 10-bit value divided by four, in 8-bit LSB units.

Each dither step lasts `STEP_CYCLES` clocks. The code register changes only at step boundaries. A strobe pulse rises one clock after each code change, so the DAC latches a settled code on its rising edge. A new value is offered with a single-cycle valid pulse. The block stages it and switches to it only when a dither period wraps, so no period mixes two values. The top base code saturates: when the higher code would pass the top of the 8-bit range, it stays at the maximum code. The usable range is 0 to 1020.

Top module: `dither_dac_codegen`

## Requirements
- R1: A synchronous reset clears the step and period counters and the active value. In the clock after a reset edge, `dac_code` is 0 and `dac_strobe` is 0.
- R2: A dither period is 4 steps. Each step is `STEP_CYCLES` clocks long (default 2), so a period is 8 clocks by default. `dac_code` changes only at a step boundary.
- R3: The active value splits into bits [9:2] as the base code and bits [1:0] as the fraction F. Steps 0 to 3 of a period are counted from the period start. At step p, `dac_code` is base+1 when p < F and base otherwise, so the higher code is held for F of the 4 steps.
- R4: When F is 0, `dac_code` holds the base code for the whole period and does not toggle.
- R5: When the base code is 255, the higher code is 255 rather than 0. Values 1021 to 1023 therefore average to 1020.
- R6: Each `load_valid` pulse stores `load_value` in a staging register, and the most recent pulse wins. The active value is replaced only at the clock edge that ends step 3 of a period. If `load_valid` is high at that edge, `load_value` is used directly.
- R7: `dac_strobe` is high for exactly one clock per step: the clock that follows each code update edge. `dac_code` is stable from the clock before its rising edge.
- R8: For every value from 0 to 1020, the sum of `dac_code` over the 4 steps of one period equals the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; advances the step and period counters |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | One-cycle pulse qualifying `load_value` |
| load_value | input | 10 | New target value: bits [9:2] base code, bits [1:0] fraction |
| dac_code | output | 8 | Code presented to the DAC |
| dac_strobe | output | 1 | DAC latch strobe; one pulse per step, rising while the code is settled |

## Verification
The bench sweeps every 10-bit value and compares the per-period code sum to the value. An off-by-one in the compare, such as `<=` in place of `<`, shows up as a wrong sum at every fraction. Values with a zero fraction are checked for no toggling, which exposes a selector that still pulses the higher code. The values above 1020 catch a higher code that wraps to 0, since their sums collapse far below 1020. A clock-by-clock model runs against loads placed at every phase of a period, including two loads inside one period and a load in the wrap clock itself. Through it the bench catches a value applied mid-period, a stale staged value, and a strobe that moves relative to the code update.

// File: rtl/dd_pkg.sv
package dd_pkg;

   // Code shown at one dither step: the higher code while step < fraction.
   function automatic logic [15:0] dd_pick(input logic [15:0] base_c,
                                           input logic [15:0] high_c,
                                           input logic [7:0]  step_idx,
                                           input logic [7:0]  frac_v);
      return (step_idx < frac_v) ? high_c : base_c;
   endfunction

endpackage

// File: rtl/dd_step_timer.sv
module dd_step_timer #(
   parameter int STEP_CYCLES = 2
) (
   input  logic clk,
   input  logic rst,
   output logic step_end,
   output logic strobe
);
   localparam int PRE_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(STEP_CYCLES - 1);

   logic [PRE_W-1:0] pre_q;

   initial begin
      assert (STEP_CYCLES >= 2) else $error("STEP_CYCLES must be at least 2");
   end

   assign step_end = (pre_q == PRE_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         pre_q  <= '0;
         strobe <= 1'b0;
      end else begin
         pre_q  <= step_end ? '0 : pre_q + 1'b1;
         strobe <= (pre_q == '0);
      end
   end

   // strobe lasts one clock per step
   p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
      strobe |=> !strobe);

   // a strobe is never high in the clock right after a step end
   p_strobe_after_edge_r7: assert property (@(posedge clk) disable iff (rst)
      $past(step_end) |-> !strobe);

endmodule

// File: rtl/dd_period_ctrl.sv
module dd_period_ctrl #(
   parameter int VAL_W  = 10,
   parameter int FRAC_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step_end,
   input  logic              load_valid,
   input  logic [VAL_W-1:0]  load_value,
   output logic [VAL_W-1:0]  active_q,
   output logic [FRAC_W-1:0] phase_q,
   output logic [VAL_W-1:0]  active_nx,
   output logic [FRAC_W-1:0] phase_nx
);
   localparam logic [FRAC_W-1:0] PH_LAST = '1;

   logic [VAL_W-1:0] staged_q;
   logic             wrap;

   initial begin
      assert (FRAC_W >= 1 && FRAC_W <= 8) else $error("FRAC_W out of range");
      assert (VAL_W > FRAC_W) else $error("VAL_W must exceed FRAC_W");
   end

   assign wrap      = step_end && (phase_q == PH_LAST);
   assign phase_nx  = step_end ? phase_q + 1'b1 : phase_q;
   assign active_nx = !wrap      ? active_q   :
                      load_valid ? load_value : staged_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         staged_q <= '0;
         active_q <= '0;
         phase_q  <= '0;
      end else begin
         if (load_valid) staged_q <= load_value;
         active_q <= active_nx;
         phase_q  <= phase_nx;
      end
   end

   // active value moves only at a period wrap
   p_hold_mid_period_r6: assert property (@(posedge clk) disable iff (rst)
      !$past(wrap) |-> $stable(active_q));

   // a period wrap always returns the phase to step 0
   p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (rst)
      $past(wrap) |-> (phase_q == '0));

endmodule

// File: rtl/dd_code_sel.sv
module dd_code_sel
   import dd_pkg::*;
#(
   parameter int CODE_W  = 8,
   parameter int FRAC_W  = 2,
   parameter bit SAT_TOP = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     step_end,
   input  logic [CODE_W+FRAC_W-1:0] active_nx,
   input  logic [FRAC_W-1:0]        phase_nx,
   output logic [CODE_W-1:0]        code_q
);
   localparam int VAL_W = CODE_W + FRAC_W;
   localparam logic [CODE_W-1:0] CODE_MAX = '1;

   logic [CODE_W-1:0] base_c;
   logic [CODE_W-1:0] high_c;
   logic [FRAC_W-1:0] frac_c;
   logic [15:0]       pick;

   initial begin
      assert (CODE_W >= 1 && CODE_W <= 16) else $error("CODE_W out of range");
   end

   assign base_c = active_nx[VAL_W-1:FRAC_W];
   assign frac_c = active_nx[FRAC_W-1:0];

   generate
      if (SAT_TOP) begin : g_sat
         assign high_c = (base_c == CODE_MAX) ? base_c : base_c + 1'b1;
      end else begin : g_wrap
         assign high_c = base_c + 1'b1;
      end
   endgenerate

   assign pick = dd_pick(16'(base_c), 16'(high_c), 8'(phase_nx), 8'(frac_c));

   always_ff @(posedge clk) begin
      if (rst) code_q <= '0;
      else if (step_end) code_q <= pick[CODE_W-1:0];
   end

   // code moves only on a step end
   p_code_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !$past(step_end) |-> $stable(code_q));

endmodule

// File: rtl/dither_dac_codegen.sv
module dither_dac_codegen #(
   parameter int CODE_W      = 8,
   parameter int FRAC_W      = 2,
   parameter int STEP_CYCLES = 2,
   parameter bit SAT_TOP     = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     load_valid,
   input  logic [CODE_W+FRAC_W-1:0] load_value,
   output logic [CODE_W-1:0]        dac_code,
   output logic                     dac_strobe
);
   localparam int VAL_W = CODE_W + FRAC_W;
   localparam logic [CODE_W-1:0] CODE_MAX = '1;

   logic              step_end;
   logic [VAL_W-1:0]  active_q;
   logic [VAL_W-1:0]  active_nx;
   logic [FRAC_W-1:0] phase_q;
   logic [FRAC_W-1:0] phase_nx;

   dd_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .step_end (step_end),
      .strobe   (dac_strobe)
   );

   dd_period_ctrl #(.VAL_W(VAL_W), .FRAC_W(FRAC_W)) u_period (
      .clk        (clk),
      .rst        (rst),
      .step_end   (step_end),
      .load_valid (load_valid),
      .load_value (load_value),
      .active_q   (active_q),
      .phase_q    (phase_q),
      .active_nx  (active_nx),
      .phase_nx   (phase_nx)
   );

   dd_code_sel #(.CODE_W(CODE_W), .FRAC_W(FRAC_W), .SAT_TOP(SAT_TOP)) u_sel (
      .clk       (clk),
      .rst       (rst),
      .step_end  (step_end),
      .active_nx (active_nx),
      .phase_nx  (phase_nx),
      .code_q    (dac_code)
   );

   // DAC latches a settled code
   p_strobe_settled_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(dac_strobe) |-> $stable(dac_code));

   // zero fraction: base code only
   p_zero_frac_r4: assert property (@(posedge clk) disable iff (rst)
      (active_q[FRAC_W-1:0] == '0) |-> (dac_code == active_q[VAL_W-1:FRAC_W]));

   generate
      if (SAT_TOP) begin : g_sat_chk
         // top base code never wraps
         p_top_saturates_r5: assert property (@(posedge clk) disable iff (rst)
            (active_q[VAL_W-1:FRAC_W] == CODE_MAX) |-> (dac_code == CODE_MAX));
      end
   endgenerate

endmodule

// File: tb/test_dither_dac_codegen.sv
`timescale 1ns/1ps
module test_dither_dac_codegen;
   localparam int STEP = 2;
   localparam int PER  = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       load_valid = 1'b0;
   logic [9:0] load_value = '0;
   logic [7:0] dac_code;
   logic       dac_strobe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int ecnt = 0;
   int m_act = 0;
   int m_stg = 0;

   always #10 clk = ~clk;

   dither_dac_codegen i_dither_dac_codegen (
      .clk(clk), .rst(rst), .load_valid(load_valid), .load_value(load_value),
      .dac_code(dac_code), .dac_strobe(dac_strobe)
   );

   function automatic int want_code(int v, int step_idx);
      int b = v / 4;
      int f = v % 4;
      int hi = (b == 255) ? 255 : b + 1;
      return (step_idx < f) ? hi : b;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference, compared every clock
   always @(posedge clk) begin
      if (rst) begin
         ecnt = 0; m_act = 0; m_stg = 0;
      end else begin
         if ((ecnt % STEP == STEP - 1) && ((ecnt / STEP) % PER == PER - 1))
            m_act = load_valid ? int'(load_value) : m_stg;
         if (load_valid) m_stg = int'(load_value);
         ecnt++;
      end
      #2;
      if (!done) begin
         check(int'(dac_code) == want_code(m_act, (ecnt / STEP) % PER),
               "R3 R6 code", int'(dac_code), want_code(m_act, (ecnt / STEP) % PER));
         check(int'(dac_strobe) == int'(ecnt % STEP == 1),
               "R7 strobe", int'(dac_strobe), int'(ecnt % STEP == 1));
      end
   end

   task automatic load(int v);
      @(negedge clk);
      load_valid = 1'b1;
      load_value = 10'(v);
      @(negedge clk);
      load_valid = 1'b0;
   endtask

   // sum of codes over 8 clocks = 2 x sum over 4 steps; also counts toggles
   task automatic measure(output int sum4, output int toggles);
      int s = 0;
      int prev = -1;
      toggles = 0;
      for (int k = 0; k < STEP * PER; k++) begin
         @(posedge clk); #3;
         s += int'(dac_code);
         if (prev >= 0 && prev != int'(dac_code)) toggles++;
         prev = int'(dac_code);
      end
      sum4 = s / STEP;
   endtask

   initial begin
      int s4;
      int tg;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(posedge clk); #3;
      check(dac_code == 8'd0, "R1 reset code", int'(dac_code), 0);

      // full sweep of values
      for (int v = 0; v < 1024; v++) begin
         load(v);
         repeat (2 * STEP * PER) @(negedge clk);
         measure(s4, tg);
         check(s4 == ((v > 1020) ? 1020 : v), (v > 1020) ? "R5 sat sum" : "R8 sum",
               s4, (v > 1020) ? 1020 : v);
         if (v % 4 == 0) check(tg == 0, "R4 no toggle", tg, 0);
      end

      // latest of two loads in one period wins
      load(37);
      load(402);
      repeat (2 * STEP * PER) @(negedge clk);
      measure(s4, tg);
      check(s4 == 402, "R6 latest wins", s4, 402);

      // loads at every clock offset of a period (model checks the timing)
      for (int off = 0; off < STEP * PER; off++) begin
         repeat (off) @(negedge clk);
         load(off * 97 + 5);
         repeat (3) @(negedge clk);
      end
      repeat (2 * STEP * PER) @(negedge clk);
      measure(s4, tg);
      check(s4 == 7 * 97 + 5, "R6 last offset load", s4, 7 * 97 + 5);

      // reset mid-run
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      #1;
      check(dac_code == 8'd0, "R1 mid reset code", int'(dac_code), 0);
      check(dac_strobe == 1'b0, "R1 mid reset strobe", int'(dac_strobe), 0);
      repeat (2 * STEP * PER) @(negedge clk);
      measure(s4, tg);
      check(s4 == 0, "R1 value cleared", s4, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule